// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This block decides where a 32-bit RISC core fetches next. For each instruction it takes the current program counter, a small code that says what kind of control transfer the instruction is, the 16-bit branch offset, the 26-bit jump field, and the two source register values. It returns the next program counter, a flag that says whether control left the sequential path, and a request to write a return address into the link register.

Four families share one decision. The first is compare branches on two registers (equal, not equal). The second is sign tests of a single register against zero, which also come in forms that record a return address. The third is direct jumps, which stay within the current 256 MB region. The fourth is a jump through a register. The unit has a one-deep output register and valid/ready handshakes on both sides. An input is accepted when `in_valid` and `in_ready` are both high at a clock edge. A result leaves when `out_valid` and `out_ready` are both high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. While `out_ready` is low, a held result does not change. All program counters given to the unit are word aligned.

Top module: `nextpc_unit`

## Requirements
- R1: While reset is asserted and after it is released, with no input accepted, `out_valid` is 0 and `in_ready` is 1.
- R2: `in_ready` equals `!out_valid || out_ready`. An accepted input shows its result on the outputs with `out_valid` high in the cycle after acceptance. While `out_valid` is high and `out_ready` is low, every output holds its value.
- R3: For kind 0 (sequential) and the unused kinds 12 to 15, and for any branch whose condition is false, the next PC is PC+4 (modulo 2^32), taken is 0 and no link is requested.
- R4: Kind 1 takes when the two register values are equal. Kind 2 takes when they differ. A taken branch goes to PC + 4 + (sign-extended offset × 4).
- R5: Kinds 3 (≤ 0), 4 (> 0), 5 (< 0) and 6 (≥ 0) test only the first register value against zero as a signed number. The second register value has no effect. A taken branch goes to the same target as in R4.
- R6: Kinds 7 (< 0) and 8 (≥ 0) branch like R5 and request a link write only when their condition holds.
- R7: Kind 9 jumps to {bits 31..28 of PC+4, 26-bit field, 2'b00} with taken set.
- R8: Kind 10 jumps to the same target as R7, sets taken and always requests a link write.
- R9: Kind 11 jumps to the first register value with its two low bits cleared, with taken set. Every taken target has its two low bits at 0.
- R10: Whenever a link write is requested, the link value is PC+4 and the link register index is 31.
- R11: A link write is never requested without taken being set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction fields are present |
| in_ready | output | 1 | Unit can accept an instruction this cycle |
| in_pc | input | 32 | Program counter of the instruction (word aligned) |
| in_kind | input | 4 | Control-transfer kind code (see R3 to R9) |
| in_offset | input | 16 | Signed branch offset in words |
| in_target | input | 26 | Direct jump field |
| in_rs_val | input | 32 | First source register value |
| in_rt_val | input | 32 | Second source register value |
| out_valid | output | 1 | A result is held |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_next_pc | output | 32 | Next program counter |
| out_taken | output | 1 | Control left the sequential path |
| out_link_we | output | 1 | Request to write the return address |
| out_link_reg | output | 5 | Index of the link register |
| out_link_val | output | 32 | Return address to write |

## Verification
The bench covers the zero boundary of every sign test: a value of 0, a value of 1, all ones and the most negative value. A design that treats zero as negative, or compares unsigned, would then take `bgtz`/`bgez`-style branches the wrong way. It covers offsets at both ends of the signed range, where a design that zero-extends jumps forward instead of backward. It covers a direct jump at PC 0x7FFFFFFC, whose region bits must come from PC+4 and not from PC, and a link branch whose condition fails, which must not write the link register. Back-pressure is applied at random, and a design that lets a held result change while stalled, or that drops or duplicates a result, is caught by the reference queue.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;

  typedef enum logic [3:0] {
    FLOW_SEQ       = 4'd0,
    FLOW_EQ        = 4'd1,
    FLOW_NE        = 4'd2,
    FLOW_LEZ       = 4'd3,
    FLOW_GTZ       = 4'd4,
    FLOW_LTZ       = 4'd5,
    FLOW_GEZ       = 4'd6,
    FLOW_LTZ_LINK  = 4'd7,
    FLOW_GEZ_LINK  = 4'd8,
    FLOW_JUMP      = 4'd9,
    FLOW_JUMP_LINK = 4'd10,
    FLOW_JUMP_REG  = 4'd11
  } flow_kind_e;

  typedef enum logic [1:0] {
    SEL_SEQ    = 2'd0,
    SEL_BRANCH = 2'd1,
    SEL_REGION = 2'd2,
    SEL_REG    = 2'd3
  } target_sel_e;

endpackage

// File: rtl/nextpc_cond.sv
module nextpc_cond
  import nextpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [3:0]      kind,
  input  logic [XLEN-1:0] rs_val,
  input  logic [XLEN-1:0] rt_val,
  output target_sel_e     sel,
  output logic            link
);

  logic rs_neg, rs_zero, regs_eq;

  assign rs_neg  = rs_val[XLEN-1];
  assign rs_zero = (rs_val == '0);
  assign regs_eq = (rs_val == rt_val);

  always_comb begin
    sel  = SEL_SEQ;
    link = 1'b0;
    case (kind)
      FLOW_EQ:        if (regs_eq)             sel = SEL_BRANCH;
      FLOW_NE:        if (!regs_eq)            sel = SEL_BRANCH;
      FLOW_LEZ:       if (rs_neg || rs_zero)   sel = SEL_BRANCH;
      FLOW_GTZ:       if (!rs_neg && !rs_zero) sel = SEL_BRANCH;
      FLOW_LTZ:       if (rs_neg)              sel = SEL_BRANCH;
      FLOW_GEZ:       if (!rs_neg)             sel = SEL_BRANCH;
      FLOW_LTZ_LINK:  if (rs_neg) begin
                        sel  = SEL_BRANCH;
                        link = 1'b1;
                      end
      FLOW_GEZ_LINK:  if (!rs_neg) begin
                        sel  = SEL_BRANCH;
                        link = 1'b1;
                      end
      FLOW_JUMP:      sel = SEL_REGION;
      FLOW_JUMP_LINK: begin
                        sel  = SEL_REGION;
                        link = 1'b1;
                      end
      FLOW_JUMP_REG:  sel = SEL_REG;
      default:        sel = SEL_SEQ;
    endcase
  end

  // Link requests only come from the three linking kinds (R6, R8)
  assert_link_kind_R6: assert property (@(posedge clk) disable iff (!rst_n)
    link |-> (kind == FLOW_LTZ_LINK || kind == FLOW_GEZ_LINK || kind == FLOW_JUMP_LINK));

  // Unused kind codes fall back to the sequential path (R3)
  assert_unused_seq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kind >= 4'd12) |-> (sel == SEL_SEQ && !link));

endmodule

// File: rtl/nextpc_target.sv
module nextpc_target
  import nextpc_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int OFF_W = 16,
  parameter int JT_W  = 26
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [OFF_W-1:0] offset,
  input  logic [JT_W-1:0]  jfield,
  input  logic [XLEN-1:0]  rs_val,
  input  target_sel_e      sel,
  output logic [XLEN-1:0]  pc_seq,
  output logic [XLEN-1:0]  next_pc
);

  localparam int EXT_W    = XLEN - OFF_W - 2;
  localparam int REGION_W = XLEN - JT_W - 2;
  localparam logic [XLEN-1:0] WORD_MASK = {{(XLEN-2){1'b1}}, 2'b00};

  logic [XLEN-1:0] off_bytes, br_tgt, region_tgt, reg_tgt;

  assign pc_seq    = pc + XLEN'(4);
  assign off_bytes = {{EXT_W{offset[OFF_W-1]}}, offset, 2'b00};
  assign br_tgt    = pc_seq + off_bytes;
  assign reg_tgt   = rs_val & WORD_MASK;

  generate
    if (REGION_W > 0) begin : g_region
      assign region_tgt = {pc_seq[XLEN-1 -: REGION_W], jfield, 2'b00};
    end else begin : g_flat
      assign region_tgt = XLEN'({jfield, 2'b00});
    end
  endgenerate

  always_comb begin
    case (sel)
      SEL_BRANCH: next_pc = br_tgt;
      SEL_REGION: next_pc = region_tgt;
      SEL_REG:    next_pc = reg_tgt;
      default:    next_pc = pc_seq;
    endcase
  end

endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int OFF_W    = 16,
  parameter int JT_W     = 26,
  parameter int REG_AW   = 5,
  parameter int LINK_IDX = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [XLEN-1:0]   in_pc,
  input  logic [3:0]        in_kind,
  input  logic [OFF_W-1:0]  in_offset,
  input  logic [JT_W-1:0]   in_target,
  input  logic [XLEN-1:0]   in_rs_val,
  input  logic [XLEN-1:0]   in_rt_val,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [XLEN-1:0]   out_next_pc,
  output logic              out_taken,
  output logic              out_link_we,
  output logic [REG_AW-1:0] out_link_reg,
  output logic [XLEN-1:0]   out_link_val
);

  target_sel_e     sel;
  logic            link_req;
  logic [XLEN-1:0] pc_seq, next_pc;

  nextpc_cond #(.XLEN(XLEN)) u_cond (
    .clk    (clk),
    .rst_n  (rst_n),
    .kind   (in_kind),
    .rs_val (in_rs_val),
    .rt_val (in_rt_val),
    .sel    (sel),
    .link   (link_req)
  );

  nextpc_target #(.XLEN(XLEN), .OFF_W(OFF_W), .JT_W(JT_W)) u_target (
    .pc      (in_pc),
    .offset  (in_offset),
    .jfield  (in_target),
    .rs_val  (in_rs_val),
    .sel     (sel),
    .pc_seq  (pc_seq),
    .next_pc (next_pc)
  );

  assign in_ready     = !out_valid || out_ready;
  assign out_link_reg = REG_AW'(LINK_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_next_pc  <= '0;
      out_taken    <= 1'b0;
      out_link_we  <= 1'b0;
      out_link_val <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_next_pc  <= next_pc;
        out_taken    <= (sel != SEL_SEQ);
        out_link_we  <= link_req;
        out_link_val <= pc_seq;
      end
    end
  end

  // A stalled result stays put (R2)
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_next_pc) && $stable(out_taken)
                                   && $stable(out_link_we) && $stable(out_link_val)));

  // An accepted input is presented on the next cycle (R2)
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // Link write implies taken (R11)
  assert_link_taken_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_link_we) |-> out_taken);

  // Taken targets are word aligned (R9)
  assert_aligned_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_taken && in_pc[1:0] == 2'b00 && $past(in_pc[1:0]) == 2'b00)
      |-> (out_next_pc[1:0] == 2'b00));

endmodule

// File: tb/tb_nextpc_unit.sv
module tb_nextpc_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_pc = '0;
  logic [3:0]  in_kind = '0;
  logic [15:0] in_offset = '0;
  logic [25:0] in_target = '0;
  logic [31:0] in_rs_val = '0;
  logic [31:0] in_rt_val = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_next_pc;
  logic        out_taken;
  logic        out_link_we;
  logic [4:0]  out_link_reg;
  logic [31:0] out_link_val;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;
  bit run_mon = 1'b0;

  logic [31:0] q_npc[$];
  logic        q_tk[$];
  logic        q_lk[$];
  logic [31:0] q_lv[$];
  logic [3:0]  q_kind[$];

  always #2 clk = ~clk;

  nextpc_unit dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pc(in_pc), .in_kind(in_kind), .in_offset(in_offset), .in_target(in_target),
    .in_rs_val(in_rs_val), .in_rt_val(in_rt_val), .out_valid(out_valid),
    .out_ready(out_ready), .out_next_pc(out_next_pc), .out_taken(out_taken),
    .out_link_we(out_link_we), .out_link_reg(out_link_reg), .out_link_val(out_link_val)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string kind_tag(input logic [3:0] k);
    case (k)
      4'd1, 4'd2:                return "R4";
      4'd3, 4'd4, 4'd5, 4'd6:    return "R5";
      4'd7, 4'd8:                return "R6";
      4'd9:                      return "R7";
      4'd10:                     return "R8";
      4'd11:                     return "R9";
      default:                   return "R3";
    endcase
  endfunction

  // Behavioural reference from the requirements
  task automatic model(input logic [3:0] k, input logic [31:0] pc, input logic [15:0] off,
                       input logic [25:0] tg, input logic [31:0] rs, input logic [31:0] rt);
    logic [31:0] seq, br, jt, npc;
    logic tk, lk, cond;
    int srs;
    seq = pc + 32'd4;
    br  = seq + (32'($signed(off)) * 32'd4);
    jt  = {seq[31:28], tg, 2'b00};
    srs = $signed(rs);
    cond = 1'b0; lk = 1'b0; npc = seq; tk = 1'b0;
    case (k)
      4'd1: cond = (rs == rt);
      4'd2: cond = (rs != rt);
      4'd3: cond = (srs <= 0);
      4'd4: cond = (srs > 0);
      4'd5, 4'd7: cond = (srs < 0);
      4'd6, 4'd8: cond = (srs >= 0);
      default: cond = 1'b0;
    endcase
    if (k >= 4'd1 && k <= 4'd8 && cond) begin
      npc = br; tk = 1'b1; lk = (k >= 4'd7);
    end else if (k == 4'd9) begin
      npc = jt; tk = 1'b1;
    end else if (k == 4'd10) begin
      npc = jt; tk = 1'b1; lk = 1'b1;
    end else if (k == 4'd11) begin
      npc = {rs[31:2], 2'b00}; tk = 1'b1;
    end
    q_npc.push_back(npc); q_tk.push_back(tk); q_lk.push_back(lk);
    q_lv.push_back(seq); q_kind.push_back(k);
  endtask

  // Monitor: random back-pressure, compare every transfer, check stalls
  logic        st_prev = 1'b0;
  logic [31:0] st_npc, st_lv;
  logic        st_tk, st_lk;
  initial begin
    forever begin
      @(negedge clk);
      out_ready = ($urandom_range(0, 3) != 0);
      #1.5;
      if (run_mon) begin
        if (st_prev) begin
          chk("R2", {31'd0, out_valid}, 32'd1);
          chk("R2", out_next_pc, st_npc);
          chk("R2", {30'd0, out_taken, out_link_we}, {30'd0, st_tk, st_lk});
          chk("R2", out_link_val, st_lv);
        end
        chk("R2", {31'd0, in_ready}, {31'd0, (!out_valid || out_ready)});
        if (out_valid && out_ready) begin
          if (q_npc.size() == 0) begin
            chk("R2", 32'd1, 32'd0);
          end else begin
            logic [3:0] k;
            logic lk;
            k = q_kind.pop_front();
            lk = q_lk.pop_front();
            chk(kind_tag(k), out_next_pc, q_npc.pop_front());
            chk(kind_tag(k), {31'd0, out_taken}, {31'd0, q_tk.pop_front()});
            chk(k >= 4'd7 && k <= 4'd10 ? "R6" : "R3", {31'd0, out_link_we}, {31'd0, lk});
            if (lk) begin
              chk("R10", out_link_val, q_lv.pop_front());
              chk("R10", {27'd0, out_link_reg}, 32'd31);
              chk("R11", {31'd0, out_taken}, 32'd1);
            end else begin
              void'(q_lv.pop_front());
            end
          end
        end
        if (in_valid && in_ready)
          model(in_kind, in_pc, in_offset, in_target, in_rs_val, in_rt_val);
        st_prev = out_valid && !out_ready;
        st_npc = out_next_pc; st_tk = out_taken; st_lk = out_link_we; st_lv = out_link_val;
      end
    end
  end

  task automatic send(input logic [3:0] k, input logic [31:0] pc, input logic [15:0] off,
                      input logic [25:0] tg, input logic [31:0] rs, input logic [31:0] rt);
    bit acc;
    @(negedge clk);
    in_valid = 1'b1; in_kind = k; in_pc = pc; in_offset = off;
    in_target = tg; in_rs_val = rs; in_rt_val = rt;
    acc = 1'b0;
    while (!acc) begin
      #1;
      acc = in_ready;
      if (!acc) @(negedge clk);
    end
    @(negedge clk);
    in_valid = ($urandom_range(0, 4) == 0) ? 1'b0 : 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", {30'd0, out_valid, in_ready}, {30'd0, 1'b0, 1'b1});
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    #1;
    chk("R1", {31'd0, out_valid}, 32'd0);
    run_mon = 1'b1;

    // R3 sequential and unused kinds, including wrap
    send(4'd0, 32'h0000_1000, 16'h0010, 26'h123, 32'd1, 32'd1);
    for (int k = 12; k < 16; k++) send(4'(k), 32'hFFFF_FFFC, 16'h0001, 26'h3FF_FFFF, 32'd0, 32'd0);
    // R4 register compares, offset extremes
    send(4'd1, 32'h0040_0000, 16'h8000, 26'd0, 32'd5, 32'd5);
    send(4'd1, 32'h0040_0000, 16'h8000, 26'd0, 32'd5, 32'd6);
    send(4'd2, 32'h0040_0000, 16'h7FFF, 26'd0, 32'd5, 32'd6);
    send(4'd2, 32'h0040_0000, 16'h7FFF, 26'd0, 32'd7, 32'd7);
    send(4'd2, 32'h0040_0010, 16'hFFFF, 26'd0, 32'h8000_0000, 32'd0);
    // R5 sign tests at the zero boundary, rt ignored
    foreach (q_npc[i]) ; // no-op
    for (int k = 3; k <= 6; k++) begin
      send(4'(k), 32'h0010_0000, 16'h0004, 26'd0, 32'd0, 32'hFFFF_FFFF);
      send(4'(k), 32'h0010_0000, 16'h0004, 26'd0, 32'd1, 32'd0);
      send(4'(k), 32'h0010_0000, 16'hFFFC, 26'd0, 32'hFFFF_FFFF, 32'd1);
      send(4'(k), 32'h0010_0000, 16'hFFFC, 26'd0, 32'h8000_0000, 32'd0);
    end
    // R6 link branches, both outcomes
    send(4'd7, 32'h0020_0000, 16'h0008, 26'd0, 32'hFFFF_FFFF, 32'd0);
    send(4'd7, 32'h0020_0000, 16'h0008, 26'd0, 32'd0, 32'd0);
    send(4'd8, 32'h0020_0000, 16'h0008, 26'd0, 32'd0, 32'd0);
    send(4'd8, 32'h0020_0000, 16'h0008, 26'd0, 32'h8000_0000, 32'd0);
    // R7 region from PC+4 at the boundary
    send(4'd9, 32'h7FFF_FFFC, 16'd0, 26'h3FF_FFFF, 32'd0, 32'd0);
    send(4'd9, 32'h1234_5678, 16'd0, 26'h000_0001, 32'd0, 32'd0);
    // R8 jump and link
    send(4'd10, 32'hF000_0010, 16'd0, 26'h000_0001, 32'd0, 32'd0);
    // R9 register jump, low bits cleared
    send(4'd11, 32'h0000_0100, 16'd0, 26'd0, 32'h0040_3003, 32'd0);
    send(4'd11, 32'h0000_0100, 16'd0, 26'd0, 32'hFFFF_FFFF, 32'd0);

    for (int n = 0; n < 400; n++) begin
      logic [31:0] rs, rt;
      rs = $urandom;
      rt = ($urandom_range(0, 3) == 0) ? rs : $urandom;
      case ($urandom_range(0, 3))
        0: rs = 32'd0;
        1: rs = $urandom_range(0, 2) - 1;
        default: ;
      endcase
      send(4'($urandom_range(0, 15)), $urandom & 32'hFFFF_FFFC, 16'($urandom),
           26'($urandom), rs, rt);
    end

    in_valid = 1'b0;
    while (q_npc.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule